// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block belongs to the decode stage of a five-stage in-order pipeline. Each cycle it decides whether the instruction now held in the fetch/decode register may issue into execute. When a load is in the execute stage, its result reaches the pipeline too late to be forwarded to the very next instruction. In that case, if the decoded instruction reads the load's destination register, the block holds that instruction back for one cycle.

It uses three inputs: the class and source register fields of the decoded instruction, a flag that says the execute-stage occupant is a load, and that load's destination register. On a hazard it raises three controls together:
- a hold for the program counter;
- a hold for the fetch/decode register, so that the register reloads itself and keeps the stalled instruction;
- a bubble control, which turns only the control portion of the decode/execute register into a no-op.

Nothing is flushed. After the single bubble, the load has moved on to memory access, and forwarding from the load-data register provides the operand.

Top module: `lu_stall_unit`

## Requirements
- R1: With `rst_n` high, `id_valid` high, `ex_is_load` high and `ex_dst` nonzero, the stall controls go high in the same cycle when `ex_dst` equals `id_rs` and `id_cls` names a class that reads its first source. Those classes are 0 (register-register ALU), 1 (register-immediate ALU), 2 (load), 3 (store), 4 (two-register branch) and 6 (branch on zero).
- R2: A match between `ex_dst` and `id_rt` causes a stall only for classes 0, 3 and 4, which read their second field. For classes 1, 2 and 6 the second field is not read, so such a match alone gives no stall.
- R3: An `ex_dst` of 0 never causes a stall, whatever the source fields hold.
- R4: When `ex_is_load` is low, no stall occurs, even when the register numbers match.
- R5: When `id_valid` is low, or `id_cls` is 5 or 7 (no-op classes), no stall occurs.
- R6: `pc_hold`, `ifid_hold` and `idex_bubble` always carry the same value.
- R7: In a pipeline that applies the bubble, a stall lasts exactly one cycle. In the next cycle the held instruction issues with no stall.
- R8: While `rst_n` is low, all three stall controls are low, whatever the other inputs hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (used by the internal assertions) |
| rst_n | input | 1 | Active-low reset; forces the controls low |
| id_valid | input | 1 | Fetch/decode register holds a real instruction |
| id_cls | input | 3 | Class of the decoded instruction (encoding in R1, R2, R5) |
| id_rs | input | REG_AW | First source register field of the decoded instruction |
| id_rt | input | REG_AW | Second register field of the decoded instruction |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| ex_dst | input | REG_AW | Destination register of the execute-stage instruction |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Reload the fetch/decode register with its own contents |
| idex_bubble | output | 1 | Write no-op control fields into the decode/execute register |

## Verification
The assertions check four things on every cycle:
- a first-source match behind a load always stalls;
- a zero destination, an execute occupant that is not a load, or an empty or no-op decode slot never stalls;
- the classes that use their second field as a destination never ask for it as a source;
- no stall follows a stall.

The bench models the decode/execute register in front of the block, so its scenarios are what show the class-by-class choice of which fields are compared, chained load-after-load stalls, the reset override, and that the held instruction issues after exactly one bubble.

// File: rtl/lus_pkg.sv
`timescale 1ns/1ps
package lus_pkg;

  localparam int CLS_W   = 3;
  localparam int NUM_SRC = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_ALU_RR = 3'd0,
    CLS_ALU_RI = 3'd1,
    CLS_LOAD   = 3'd2,
    CLS_STORE  = 3'd3,
    CLS_BR_TWO = 3'd4,
    CLS_NOP    = 3'd5,
    CLS_BR_Z   = 3'd6,
    CLS_RSVD   = 3'd7
  } iclass_e;

  // First source field: read by every class that does real work.
  function automatic logic uses_first_src(iclass_e c);
    return !(c == CLS_NOP || c == CLS_RSVD);
  endfunction

  // Second field is a source only where it is not a destination.
  function automatic logic uses_second_src(iclass_e c);
    unique case (c)
      CLS_ALU_RR, CLS_STORE, CLS_BR_TWO: return 1'b1;
      default:                           return 1'b0;
    endcase
  endfunction

  // Register match that can never trigger on the hardwired zero register.
  function automatic logic reg_collides(logic [7:0] dst, logic [7:0] src);
    return (dst != 8'd0) && (dst == src);
  endfunction

endpackage

// File: rtl/lus_src_decode.sv
`timescale 1ns/1ps
module lus_src_decode
  import lus_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid,
  input  iclass_e            cls,
  output logic [NUM_SRC-1:0] need
);

  always_comb begin
    need    = '0;
    need[0] = valid && uses_first_src(cls);
    need[1] = valid && uses_second_src(cls);
  end

  // R5: an empty slot or a no-op class asks for no operand.
  assert_nop_reads_none_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid || cls == CLS_NOP || cls == CLS_RSVD) |-> (need == '0));

  // R2: classes whose second field is a destination never request it.
  assert_rt_dest_not_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == CLS_ALU_RI || cls == CLS_LOAD || cls == CLS_BR_Z) |-> !need[1]);

endmodule

// File: rtl/lus_src_match.sv
`timescale 1ns/1ps
module lus_src_match
  import lus_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_SRC-1:0][REG_AW-1:0] src,
  input  logic [NUM_SRC-1:0]             need,
  input  logic                           ex_is_load,
  input  logic [REG_AW-1:0]              ex_dst,
  output logic                           hit_any
);

  localparam int PAD = 8 - REG_AW;

  logic [NUM_SRC-1:0] hit_vec;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    always_comb begin
      hit_vec[g] = need[g] && ex_is_load &&
                   reg_collides({{PAD{1'b0}}, ex_dst}, {{PAD{1'b0}}, src[g]});
    end
  end

  assign hit_any = |hit_vec;

  // R3: the zero register is never a hazard source.
  assert_zero_dst_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_dst == '0) |-> !hit_any);

  // R4: only a load in execute can create a hazard here.
  assert_nonload_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_is_load |-> !hit_any);

endmodule

// File: rtl/lus_stall_ctrl.sv
`timescale 1ns/1ps
module lus_stall_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic hazard,
  output logic pc_hold,
  output logic ifid_hold,
  output logic idex_bubble
);

  logic stall;

  assign stall       = rst_n && hazard;
  assign pc_hold     = stall;
  assign ifid_hold   = stall;
  assign idex_bubble = stall;

  // R7: the bubble clears the load from execute, so stalls never chain.
  assert_single_cycle_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

endmodule

// File: rtl/lu_stall_unit.sv
`timescale 1ns/1ps
module lu_stall_unit
  import lus_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_valid,
  input  logic [2:0]        id_cls,
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic              ex_is_load,
  input  logic [REG_AW-1:0] ex_dst,
  output logic              pc_hold,
  output logic              ifid_hold,
  output logic              idex_bubble
);

  iclass_e                       cls;
  logic [NUM_SRC-1:0]            need;
  logic [NUM_SRC-1:0][REG_AW-1:0] src;
  logic                          hazard;

  assign cls    = iclass_e'(id_cls);
  assign src[0] = id_rs;
  assign src[1] = id_rt;

  lus_src_decode u_decode (
    .clk   (clk),
    .rst_n (rst_n),
    .valid (id_valid),
    .cls   (cls),
    .need  (need)
  );

  lus_src_match #(.REG_AW(REG_AW)) u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .src        (src),
    .need       (need),
    .ex_is_load (ex_is_load),
    .ex_dst     (ex_dst),
    .hit_any    (hazard)
  );

  lus_stall_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .hazard      (hazard),
    .pc_hold     (pc_hold),
    .ifid_hold   (ifid_hold),
    .idex_bubble (idex_bubble)
  );

  // R1: a first-source dependence on a load always holds the front end.
  assert_rs_dep_stalls_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && uses_first_src(cls) && ex_is_load &&
     ex_dst != '0 && ex_dst == id_rs) |-> (pc_hold && ifid_hold && idex_bubble));

  // R5: an empty decode slot never holds the front end.
  assert_empty_slot_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |-> !pc_hold);

endmodule

// File: tb/lu_stall_unit_tb_top.sv
`timescale 1ns/1ps
module lu_stall_unit_tb_top;

  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          id_valid = 1'b0;
  logic [2:0]    id_cls = 3'd5;
  logic [AW-1:0] id_rs = '0;
  logic [AW-1:0] id_rt = '0;
  logic          ex_is_load = 1'b0;
  logic [AW-1:0] ex_dst = '0;
  logic          pc_hold, ifid_hold, idex_bubble;

  always #10 clk = ~clk;

  lu_stall_unit #(.REG_AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_cls(id_cls),
    .id_rs(id_rs), .id_rt(id_rt), .ex_is_load(ex_is_load), .ex_dst(ex_dst),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble)
  );

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  item_t sbq[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 0;

  // Bench model of the decode/execute register contents.
  logic          m_ex_load = 1'b0;
  logic [AW-1:0] m_ex_dst  = '0;

  function automatic logic predict(logic r, logic v, logic [2:0] c,
                                   logic [AW-1:0] rs, logic [AW-1:0] rt,
                                   logic ld, logic [AW-1:0] d);
    logic rd_rs, rd_rt;
    rd_rs = (c <= 3'd4) || (c == 3'd6);
    rd_rt = (c == 3'd0) || (c == 3'd3) || (c == 3'd4);
    if (!r || !v || !ld || d == 0) return 1'b0;
    return (rd_rs && rs == d) || (rd_rt && rt == d);
  endfunction

  task automatic expect_now(logic e, string tag);
    item_t it;
    it.exp = e;
    it.tag = tag;
    sbq.push_back(it);
  endtask

  // Monitor: samples mid-low-phase, pops expectations in order.
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        n_checks++;
        if ({pc_hold, ifid_hold, idex_bubble} !== {3{it.exp}}) begin
          n_fail++;
          $display("FAIL %s (R6 outputs agree): actual pc/ifid/idex=%b%b%b expected=%b%b%b",
                   it.tag, pc_hold, ifid_hold, idex_bubble, it.exp, it.exp, it.exp);
        end
      end
    end
  end

  // Driver: presents one instruction and retries it once if it stalls.
  task automatic issue(logic [2:0] c, logic [AW-1:0] rs, logic [AW-1:0] rt,
                       logic v, logic exp_chk, string tag);
    logic e;
    @(negedge clk);
    id_valid = v; id_cls = c; id_rs = rs; id_rt = rt;
    ex_is_load = m_ex_load; ex_dst = m_ex_dst;
    e = predict(rst_n, v, c, rs, rt, m_ex_load, m_ex_dst);
    if (e !== exp_chk) begin
      n_fail++;
      $display("FAIL %s scenario setup: actual model=%b expected=%b", tag, e, exp_chk);
    end
    expect_now(e, tag);
    @(posedge clk);
    if (e) begin
      m_ex_load = 1'b0;
      m_ex_dst  = '0;
      @(negedge clk);
      ex_is_load = m_ex_load; ex_dst = m_ex_dst;
      expect_now(1'b0, "R7 held instruction issues after one bubble");
      @(posedge clk);
    end
    m_ex_load = v && (c == 3'd2);
    m_ex_dst  = v ? rt : '0;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R8: reset overrides a live hazard on the inputs.
    @(negedge clk);
    id_valid = 1; id_cls = 3'd0; id_rs = 5'd5; id_rt = 5'd5;
    ex_is_load = 1; ex_dst = 5'd5;
    expect_now(1'b0, "R8 reset forces controls low");
    @(negedge clk);
    expect_now(1'b0, "R8 reset second cycle");
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    id_valid = 0; ex_is_load = 0; ex_dst = '0;

    issue(3'd2, 5'd1, 5'd5, 1, 0, "R1 load enters empty pipe");
    issue(3'd0, 5'd5, 5'd2, 1, 1, "R1 rs depends on load");

    issue(3'd2, 5'd3, 5'd6, 1, 0, "R2 load before rr");
    issue(3'd0, 5'd2, 5'd6, 1, 1, "R2 rr reads rt");
    issue(3'd2, 5'd3, 5'd7, 1, 0, "R2 load before store");
    issue(3'd3, 5'd1, 5'd7, 1, 1, "R2 store data reads rt");
    issue(3'd2, 5'd3, 5'd8, 1, 0, "R2 load before branch");
    issue(3'd4, 5'd0, 5'd8, 1, 1, "R2 two-register branch reads rt");
    issue(3'd2, 5'd3, 5'd9, 1, 0, "R2 load before imm");
    issue(3'd1, 5'd1, 5'd9, 1, 0, "R2 imm rt is destination");
    issue(3'd2, 5'd3, 5'd10, 1, 0, "R2 load before load");
    issue(3'd2, 5'd2, 5'd10, 1, 0, "R2 load rt is destination");
    issue(3'd2, 5'd3, 5'd11, 1, 0, "R2 load before zero branch");
    issue(3'd6, 5'd3, 5'd11, 1, 0, "R2 zero branch ignores rt");
    issue(3'd2, 5'd3, 5'd11, 1, 0, "R1 load before zero branch");
    issue(3'd6, 5'd11, 5'd0, 1, 1, "R1 zero branch reads rs");

    issue(3'd2, 5'd3, 5'd0, 1, 0, "R3 load to zero register");
    issue(3'd0, 5'd0, 5'd0, 1, 0, "R3 zero destination ignored");

    issue(3'd1, 5'd3, 5'd12, 1, 0, "R4 non-load producer");
    issue(3'd0, 5'd12, 5'd12, 1, 0, "R4 no stall behind non-load");

    issue(3'd2, 5'd3, 5'd13, 1, 0, "R5 load before nop");
    issue(3'd5, 5'd13, 5'd13, 1, 0, "R5 nop class ignored");
    issue(3'd2, 5'd3, 5'd14, 1, 0, "R5 load before bubble slot");
    issue(3'd0, 5'd14, 5'd14, 0, 0, "R5 invalid slot ignored");
    issue(3'd2, 5'd3, 5'd17, 1, 0, "R5 load before reserved class");
    issue(3'd7, 5'd17, 5'd17, 1, 0, "R5 reserved class ignored");

    issue(3'd2, 5'd3, 5'd15, 1, 0, "R1 load chain start");
    issue(3'd2, 5'd15, 5'd16, 1, 1, "R1 load address depends on load");
    issue(3'd0, 5'd16, 5'd1, 1, 1, "R1 rr depends on second load");
    issue(3'd2, 5'd3, 5'd31, 1, 0, "R1 load top register");
    issue(3'd3, 5'd31, 5'd31, 1, 1, "R1 store both fields match");

    @(negedge clk);
    @(negedge clk);
    #8;
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule